// File: doc/BRIEF.md
# Machine-Cycle and Clock-State Sequencer

This block paces the bus activity of an 8-bit processor core. Each instruction is described by a small descriptor: how many prefix bytes precede the main opcode, how many data transfer cycles follow it, and the type and length of each transfer. The block walks through the resulting machine cycles one clock state at a time. It reports the machine-cycle number, the clock-state number within that cycle and a one-hot strobe that marks the cycle kind: opcode fetch, memory read, memory write or I/O.

Every instruction opens with fetch cycles of four clock states each. The main opcode takes one fetch, and each prefix byte adds one more, with up to two prefixes for index-bit forms. Fetches are followed by zero to four transfer cycles of three to five states each.

When an instruction finishes, the next one may start its fetch in the very next cycle. This is not allowed if the instruction still holds the shared address incrementer. In that case the descriptor carries a hold count, and the sequencer waits that many idle states before it accepts a new descriptor. Descriptors enter on a valid/ready handshake. Ready is high only when a new fetch could begin on the following clock.

Top module: `cyc_seq`

## Requirements
- R1: After a synchronous active-high reset, `desc_ready` is 1, `cyc_strobe` is 0, `done` and `inc_wait` are 0, and `m_idx` and `t_idx` are both 0.
- R2: Every fetch machine cycle lasts exactly 4 clock states with `cyc_strobe` = 4'b0001. An instruction with no prefix and no data cycles runs 4 states in total.
- R3: `desc_pfx` (0 to 2) inserts that many extra 4-state fetch cycles ahead of the main opcode fetch. The value 3 is treated as 2.
- R4: `desc_ndata` gives 0 to 4 transfer cycles after the fetches; values 5 to 7 are treated as 4. Slot i takes its 2-bit kind from `desc_kind[2i+1:2i]`. Kind 00 drives strobe bit 1 (memory read), kind 01 drives bit 2 (memory write), and kinds 10 and 11 drive bit 3 (I/O).
- R5: Slot i lasts `desc_tlen[3i+2:3i]` clock states. Values below 3 count as 3, and values above 5 count as 5.
- R6: `m_idx` is 1 in the first machine cycle and rises by one with each new cycle. `t_idx` runs 1, 2, … within each machine cycle and restarts at 1.
- R7: `done` is high in exactly one state per instruction, its last one. The state count up to and including that state is 4·(prefixes+1) plus the sum of the effective transfer lengths.
- R8: A descriptor is taken on a clock edge where `desc_valid` and `desc_ready` are both high. While a sequence runs, `desc_ready` is low in every state except a final state with hold count 0, and the descriptor inputs have no effect on the sequence.
- R9: With `desc_inc_tail` = 0, a descriptor presented during the `done` state starts its fetch (M1, T1) in the following cycle.
- R10: With `desc_inc_tail` = N > 0, N cycles follow `done` with `inc_wait` = 1, `cyc_strobe` = 0 and `done` = 0. `desc_ready` is high only in the last of them, so a waiting descriptor starts its T1 exactly N+1 cycles after `done`.
- R11: `cyc_strobe` has at most one bit set, and it is 0 while idle or waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor can be taken this cycle |
| desc_pfx | input | 2 | Number of prefix fetches |
| desc_ndata | input | 3 | Number of transfer cycles |
| desc_kind | input | 8 | Per-slot transfer kind, 2 bits per slot |
| desc_tlen | input | 12 | Per-slot clock-state count, 3 bits per slot |
| desc_inc_tail | input | 2 | States the incrementer stays busy after the last state |
| m_idx | output | 3 | Current machine cycle, 1-based, 0 when idle |
| t_idx | output | 3 | Current clock state within the cycle, 1-based, 0 when idle |
| cyc_strobe | output | 4 | One-hot kind: bit0 fetch, bit1 mem read, bit2 mem write, bit3 I/O |
| done | output | 1 | Last clock state of the instruction |
| inc_wait | output | 1 | Waiting for the incrementer to be released |

## Verification
Two events can fall in the same cycle: the last clock state of one instruction and the acceptance of the next descriptor. The same holds for the last hold state and an acceptance. The bench provokes both by chaining two instructions, with the second descriptor driven exactly in the `done` state or in the last hold state, for every hold count from 0 to 3. It then requires the first fetch state of the second instruction to appear in the next cycle with M1/T1, with no lost or doubled state. Garbage descriptors with random valid are offered throughout each running sequence, so any leak of a busy-time acceptance shows up as a wrong strobe or index.

// File: rtl/cyc_seq_pkg.sv
package cyc_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FETCH = 2'd1,
        PH_DATA  = 2'd2,
        PH_STALL = 2'd3
    } phase_e;

    localparam int FETCH_T  = 4;
    localparam int XFER_MIN = 3;
    localparam int XFER_MAX = 5;
    localparam int KIND_W   = 2;
    localparam int STB_W    = 4;
    localparam int STB_FETCH = 0;
    localparam int STB_MRD   = 1;
    localparam int STB_MWR   = 2;
    localparam int STB_IO    = 3;
endpackage

// File: rtl/cyc_seq_norm.sv
module cyc_seq_norm
    import cyc_seq_pkg::*;
#(
    parameter int NSLOT   = 4,
    parameter int LEN_W   = 3,
    parameter int PFX_MAX = 2,
    parameter int PFX_W   = 2,
    parameter int CNT_W   = 3,
    parameter int SLOT_W  = 2
) (
    input  logic [PFX_W-1:0]       pfx_in,
    input  logic [CNT_W-1:0]       nd_in,
    input  logic [NSLOT*LEN_W-1:0] len_in,
    output logic [PFX_W-1:0]       pfx_out,
    output logic                   has_data,
    output logic [SLOT_W-1:0]      last_slot,
    output logic [NSLOT*LEN_W-1:0] len_out
);
    logic [CNT_W-1:0] nd_eff;

    always_comb begin
        pfx_out   = (pfx_in > PFX_W'(PFX_MAX)) ? PFX_W'(PFX_MAX) : pfx_in;
        nd_eff    = (nd_in > CNT_W'(NSLOT)) ? CNT_W'(NSLOT) : nd_in;
        has_data  = (nd_eff != '0);
        last_slot = SLOT_W'(nd_eff - 1'b1);
    end

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic [LEN_W-1:0] raw;
        assign raw = len_in[i*LEN_W +: LEN_W];
        assign len_out[i*LEN_W +: LEN_W] =
            (raw < LEN_W'(XFER_MIN)) ? LEN_W'(XFER_MIN) :
            (raw > LEN_W'(XFER_MAX)) ? LEN_W'(XFER_MAX) : raw;
    end
endmodule

// File: rtl/cyc_seq_strobe.sv
module cyc_seq_strobe
    import cyc_seq_pkg::*;
(
    input  phase_e              ph,
    input  logic [KIND_W-1:0]   kind,
    output logic [STB_W-1:0]    strobe
);
    always_comb begin
        strobe = '0;
        if (ph == PH_FETCH) begin
            strobe[STB_FETCH] = 1'b1;
        end else if (ph == PH_DATA) begin
            if (kind[1])      strobe[STB_IO]  = 1'b1;
            else if (kind[0]) strobe[STB_MWR] = 1'b1;
            else              strobe[STB_MRD] = 1'b1;
        end
    end
endmodule

// File: rtl/cyc_seq.sv
module cyc_seq
    import cyc_seq_pkg::*;
#(
    parameter int NSLOT   = 4,
    parameter int LEN_W   = 3,
    parameter int PFX_MAX = 2,
    parameter int TAIL_W  = 2,
    localparam int PFX_W  = $clog2(PFX_MAX + 2),
    localparam int CNT_W  = $clog2(NSLOT + 1),
    localparam int SLOT_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int M_W    = $clog2(PFX_MAX + NSLOT + 2)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    desc_valid,
    output logic                    desc_ready,
    input  logic [PFX_W-1:0]        desc_pfx,
    input  logic [CNT_W-1:0]        desc_ndata,
    input  logic [NSLOT*KIND_W-1:0] desc_kind,
    input  logic [NSLOT*LEN_W-1:0]  desc_tlen,
    input  logic [TAIL_W-1:0]       desc_inc_tail,
    output logic [M_W-1:0]          m_idx,
    output logic [LEN_W-1:0]        t_idx,
    output logic [STB_W-1:0]        cyc_strobe,
    output logic                    done,
    output logic                    inc_wait
);
    typedef struct packed {
        phase_e                    ph;
        logic [M_W-1:0]            m;
        logic [LEN_W-1:0]          t;
        logic [PFX_W-1:0]          pleft;
        logic [SLOT_W-1:0]         slot;
        logic [SLOT_W-1:0]         last_slot;
        logic                      has_data;
        logic [NSLOT*KIND_W-1:0]   kind;
        logic [NSLOT*LEN_W-1:0]    len;
        logic [TAIL_W-1:0]         tail;
        logic [TAIL_W-1:0]         wait_cnt;
    } seq_st_t;

    seq_st_t st_d, st_q;

    logic [PFX_W-1:0]        n_pfx;
    logic                    n_has_data;
    logic [SLOT_W-1:0]       n_last_slot;
    logic [NSLOT*LEN_W-1:0]  n_len;
    logic [LEN_W-1:0]        cur_len;
    logic [KIND_W-1:0]       cur_kind;
    logic                    fetch_end, data_end, last_t, accept;

    cyc_seq_norm #(
        .NSLOT(NSLOT), .LEN_W(LEN_W), .PFX_MAX(PFX_MAX),
        .PFX_W(PFX_W), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
    ) u_norm (
        .pfx_in    (desc_pfx),
        .nd_in     (desc_ndata),
        .len_in    (desc_tlen),
        .pfx_out   (n_pfx),
        .has_data  (n_has_data),
        .last_slot (n_last_slot),
        .len_out   (n_len)
    );

    cyc_seq_strobe u_strobe (
        .ph     (st_q.ph),
        .kind   (cur_kind),
        .strobe (cyc_strobe)
    );

    always_comb begin
        cur_len   = st_q.len[st_q.slot*LEN_W +: LEN_W];
        cur_kind  = st_q.kind[st_q.slot*KIND_W +: KIND_W];
        fetch_end = (st_q.ph == PH_FETCH) && (st_q.t == LEN_W'(FETCH_T));
        data_end  = (st_q.ph == PH_DATA) && (st_q.t == cur_len);
        last_t    = (fetch_end && (st_q.pleft == '0) && !st_q.has_data) ||
                    (data_end && (st_q.slot == st_q.last_slot));
        desc_ready = (st_q.ph == PH_IDLE) ||
                     (last_t && (st_q.tail == '0)) ||
                     ((st_q.ph == PH_STALL) && (st_q.wait_cnt == TAIL_W'(1)));
        accept = desc_valid && desc_ready;

        st_d = st_q;
        unique case (st_q.ph)
            PH_FETCH: begin
                if (fetch_end) begin
                    if (st_q.pleft != '0) begin
                        st_d.pleft = st_q.pleft - 1'b1;
                        st_d.m     = st_q.m + 1'b1;
                        st_d.t     = LEN_W'(1);
                    end else if (st_q.has_data) begin
                        st_d.ph   = PH_DATA;
                        st_d.slot = '0;
                        st_d.m    = st_q.m + 1'b1;
                        st_d.t    = LEN_W'(1);
                    end
                end else begin
                    st_d.t = st_q.t + 1'b1;
                end
            end
            PH_DATA: begin
                if (data_end) begin
                    if (st_q.slot != st_q.last_slot) begin
                        st_d.slot = st_q.slot + 1'b1;
                        st_d.m    = st_q.m + 1'b1;
                        st_d.t    = LEN_W'(1);
                    end
                end else begin
                    st_d.t = st_q.t + 1'b1;
                end
            end
            PH_STALL: begin
                st_d.wait_cnt = st_q.wait_cnt - 1'b1;
                if (st_q.wait_cnt == TAIL_W'(1)) st_d.ph = PH_IDLE;
            end
            default: ;
        endcase

        if (last_t) begin
            st_d.m = '0;
            st_d.t = '0;
            if (st_q.tail != '0) begin
                st_d.ph       = PH_STALL;
                st_d.wait_cnt = st_q.tail;
            end else begin
                st_d.ph = PH_IDLE;
            end
        end

        if (accept) begin
            st_d.ph        = PH_FETCH;
            st_d.m         = M_W'(1);
            st_d.t         = LEN_W'(1);
            st_d.pleft     = n_pfx;
            st_d.slot      = '0;
            st_d.last_slot = n_last_slot;
            st_d.has_data  = n_has_data;
            st_d.kind      = desc_kind;
            st_d.len       = n_len;
            st_d.tail      = desc_inc_tail;
            st_d.wait_cnt  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign m_idx    = st_q.m;
    assign t_idx    = st_q.t;
    assign done     = last_t;
    assign inc_wait = (st_q.ph == PH_STALL);
endmodule

// File: rtl/cyc_seq_chk.sv
module cyc_seq_chk #(
    parameter int M_W   = 3,
    parameter int LEN_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             desc_valid,
    input logic             desc_ready,
    input logic [M_W-1:0]   m_idx,
    input logic [LEN_W-1:0] t_idx,
    input logic [3:0]       cyc_strobe,
    input logic             done,
    input logic             inc_wait
);
    p_strobe_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cyc_strobe));

    p_fetch_len_r2: assert property (@(posedge clk) disable iff (rst)
        cyc_strobe[0] |-> (t_idx >= LEN_W'(1) && t_idx <= LEN_W'(4)));

    p_xfer_len_r5: assert property (@(posedge clk) disable iff (rst)
        (|cyc_strobe[3:1]) |-> (t_idx >= LEN_W'(1) && t_idx <= LEN_W'(5)));

    p_busy_no_ready_r8: assert property (@(posedge clk) disable iff (rst)
        (cyc_strobe != 4'b0 && !done) |-> !desc_ready);

    p_step_r6: assert property (@(posedge clk) disable iff (rst)
        (cyc_strobe != 4'b0 && !done) |=>
            ((m_idx == $past(m_idx) && t_idx == LEN_W'($past(t_idx) + 1'b1)) ||
             (m_idx == M_W'($past(m_idx) + 1'b1) && t_idx == LEN_W'(1))));

    p_chain_r9: assert property (@(posedge clk) disable iff (rst)
        (done && desc_ready && desc_valid) |=>
            (cyc_strobe == 4'b0001 && m_idx == M_W'(1) && t_idx == LEN_W'(1)));

    p_hold_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        inc_wait |-> (cyc_strobe == 4'b0 && !done));

    p_hold_follows_r10: assert property (@(posedge clk) disable iff (rst)
        (done && !desc_ready) |=> inc_wait);
endmodule

bind cyc_seq cyc_seq_chk #(.M_W(M_W), .LEN_W(LEN_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .desc_valid (desc_valid),
    .desc_ready (desc_ready),
    .m_idx      (m_idx),
    .t_idx      (t_idx),
    .cyc_strobe (cyc_strobe),
    .done       (done),
    .inc_wait   (inc_wait)
);

// File: tb/tb_cyc_seq.sv
module tb_cyc_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        desc_valid = 1'b0;
    logic        desc_ready;
    logic [1:0]  desc_pfx = '0;
    logic [2:0]  desc_ndata = '0;
    logic [7:0]  desc_kind = '0;
    logic [11:0] desc_tlen = '0;
    logic [1:0]  desc_inc_tail = '0;
    logic [2:0]  m_idx;
    logic [2:0]  t_idx;
    logic [3:0]  cyc_strobe;
    logic        done;
    logic        inc_wait;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    bit          n_go = 1'b0;
    int          n_p, n_nd, n_tail;
    logic [7:0]  n_kd;
    logic [11:0] n_tl;

    always #5 clk = ~clk;

    cyc_seq dut (
        .clk(clk), .rst(rst),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_pfx(desc_pfx), .desc_ndata(desc_ndata),
        .desc_kind(desc_kind), .desc_tlen(desc_tlen),
        .desc_inc_tail(desc_inc_tail),
        .m_idx(m_idx), .t_idx(t_idx), .cyc_strobe(cyc_strobe),
        .done(done), .inc_wait(inc_wait)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic drive_desc(input int p, input int nd, input logic [7:0] kd,
                              input logic [11:0] tl, input int tail, input bit v);
        desc_pfx      = 2'(p);
        desc_ndata    = 3'(nd);
        desc_kind     = kd;
        desc_tlen     = tl;
        desc_inc_tail = 2'(tail);
        desc_valid    = v;
    endtask

    task automatic junk();
        desc_valid    = 1'($urandom);
        desc_pfx      = 2'($urandom);
        desc_ndata    = 3'($urandom);
        desc_kind     = 8'($urandom);
        desc_tlen     = 12'($urandom);
        desc_inc_tail = 2'($urandom);
    endtask

    task automatic hand_over();
        if (n_go) drive_desc(n_p, n_nd, n_kd, n_tl, n_tail, 1'b1);
        else      desc_valid = 1'b0;
    endtask

    // Called at the negedge where M1/T1 of the instruction is visible.
    task automatic expect_instr(input int p, input int nd, input logic [7:0] kd,
                                input logic [11:0] tl, input int tail, output int meas);
        int pe, ne, nm, cyc, len, str, k, seen, tot;
        int lens[4];
        bit last;
        pe = (p > 2) ? 2 : p;
        ne = (nd > 4) ? 4 : nd;
        nm = pe + 1 + ne;
        cyc = 0;
        seen = -1;
        for (int i = 0; i < 4; i++) begin
            int v;
            v = int'(tl[3*i +: 3]);
            lens[i] = (v < 3) ? 3 : ((v > 5) ? 5 : v);
        end
        tot = 4 * (pe + 1);
        for (int i = 0; i < ne; i++) tot += lens[i];
        for (int mi = 0; mi < nm; mi++) begin
            if (mi <= pe) begin
                len = 4;
                str = 1;
            end else begin
                k   = int'(kd[2*(mi-pe-1) +: 2]);
                len = lens[mi-pe-1];
                str = (k == 0) ? 2 : ((k == 1) ? 4 : 8);
            end
            for (int t = 1; t <= len; t++) begin
                last = (mi == nm - 1) && (t == len);
                if (cyc > 0) @(negedge clk);
                chk(int'(cyc_strobe) == str, (mi <= pe) ? "R2 fetch strobe" : "R4 xfer strobe",
                    int'(cyc_strobe), str);
                chk(int'(m_idx) == mi + 1, "R6 m_idx", int'(m_idx), mi + 1);
                chk(int'(t_idx) == t, "R6 t_idx", int'(t_idx), t);
                chk(done == last, "R7 done", int'(done), int'(last));
                chk(desc_ready == (last && tail == 0), "R8 ready while running",
                    int'(desc_ready), int'(last && tail == 0));
                if (done && seen < 0) seen = cyc;
                if (last) begin
                    if (tail == 0) hand_over();
                    else junk();
                end else begin
                    junk();
                end
                cyc++;
            end
        end
        meas = seen + 1;
        chk(meas == tot, "R7 total states", meas, tot);
        for (int s = 1; s <= tail; s++) begin
            @(negedge clk);
            chk(cyc_strobe == 4'b0 && !done, "R10 hold quiet", int'({cyc_strobe, done}), 0);
            chk(inc_wait == 1'b1, "R10 inc_wait", int'(inc_wait), 1);
            chk(desc_ready == (s == tail), "R10 ready in hold", int'(desc_ready), int'(s == tail));
            if (s == tail) hand_over();
            else junk();
        end
    endtask

    task automatic idle_check(input string tag);
        chk(desc_ready == 1'b1, tag, int'(desc_ready), 1);
        chk(cyc_strobe == 4'b0, "R11 idle strobe", int'(cyc_strobe), 0);
        chk(m_idx == 3'd0 && t_idx == 3'd0, "R11 idle index", int'({m_idx, t_idx}), 0);
    endtask

    task automatic run(input int p, input int nd, input logic [7:0] kd,
                       input logic [11:0] tl, input int tail, output int meas);
        idle_check("R8 idle ready");
        n_go = 1'b0;
        drive_desc(p, nd, kd, tl, tail, 1'b1);
        @(negedge clk);
        expect_instr(p, nd, kd, tl, tail, meas);
        @(negedge clk);
        idle_check("R8 ready after end");
    endtask

    initial begin
        int meas;
        int dummy;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(desc_ready == 1'b1, "R1 ready", int'(desc_ready), 1);
        chk(cyc_strobe == 4'b0, "R1 strobe", int'(cyc_strobe), 0);
        chk(!done && !inc_wait, "R1 done/wait", int'({done, inc_wait}), 0);
        chk(m_idx == 3'd0 && t_idx == 3'd0, "R1 index", int'({m_idx, t_idx}), 0);

        // Named totals: 4, 8, 16, 20, 23
        run(0, 0, 8'h00, 12'h000, 0, meas);
        chk(meas == 4, "R2 plain 4-state", meas, 4);
        run(1, 0, 8'h00, 12'h000, 0, meas);
        chk(meas == 8, "R3 one prefix", meas, 8);
        run(0, 4, 8'b01_01_00_00, {3'd3, 3'd3, 3'd3, 3'd3}, 0, meas);
        chk(meas == 16, "R5 four 3-state slots", meas, 16);
        run(1, 4, 8'b01_01_00_00, {3'd3, 3'd3, 3'd3, 3'd3}, 0, meas);
        chk(meas == 20, "R3 prefixed four slots", meas, 20);
        run(1, 4, 8'b01_01_00_00, {3'd5, 3'd3, 3'd4, 3'd3}, 0, meas);
        chk(meas == 23, "R7 longest case", meas, 23);

        // R3/R4 sweep over prefix and slot counts including clamped values
        for (int p = 0; p < 4; p++) begin
            for (int nd = 0; nd < 8; nd++) begin
                run(p, nd, 8'b11_10_01_00, {3'd5, 3'd3, 3'd4, 3'd5}, 0, dummy);
            end
        end

        // R5 length clamp sweep
        for (int v = 0; v < 8; v++) begin
            run(0, 4, 8'b00_10_01_00, {3'(v), 3'(v), 3'(v), 3'(v)}, 0, meas);
            chk(meas == 4 + 4 * ((v < 3) ? 3 : ((v > 5) ? 5 : v)), "R5 clamp total",
                meas, 4 + 4 * ((v < 3) ? 3 : ((v > 5) ? 5 : v)));
        end

        // R10 hold without a waiting descriptor
        for (int tl = 1; tl < 4; tl++) begin
            run(2, 1, 8'b00_00_00_01, {3'd0, 3'd0, 3'd0, 3'd4}, tl, dummy);
        end

        // R9 / R10 chained instructions with every hold count
        for (int tl = 0; tl < 4; tl++) begin
            idle_check("R8 idle before chain");
            n_go = 1'b1;
            n_p = 1; n_nd = 2; n_kd = 8'b00_00_11_00; n_tl = {3'd0, 3'd0, 3'd5, 3'd3}; n_tail = 0;
            drive_desc(0, 1, 8'b00_00_00_10, {3'd0, 3'd0, 3'd0, 3'd4}, tl, 1'b1);
            @(negedge clk);
            expect_instr(0, 1, 8'b00_00_00_10, {3'd0, 3'd0, 3'd0, 3'd4}, tl, dummy);
            n_go = 1'b0;
            @(negedge clk);
            chk(cyc_strobe == 4'b0001 && m_idx == 3'd1 && t_idx == 3'd1,
                (tl == 0) ? "R9 next fetch at once" : "R10 next fetch after hold",
                int'({cyc_strobe, m_idx, t_idx}), int'({4'b0001, 3'd1, 3'd1}));
            expect_instr(1, 2, 8'b00_00_11_00, {3'd0, 3'd0, 3'd5, 3'd3}, 0, meas);
            chk(meas == 16, "R9 chained total", meas, 16);
            @(negedge clk);
            idle_check("R8 ready after chain");
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL R7 watchdog: actual no completion expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule